// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

When a core accepts an external maskable interrupt, this block performs the bus handshake that fetches the interrupt type from an external interrupt controller. It runs a pair of acknowledge bus cycles back to back. Each cycle steps through the four bus states T1, T2, T3 and T4. While it does this it drives an address latch enable, an active-low acknowledge strobe and a bus lock output. It also tells a bus-hold arbiter whether a pending hold request may be granted at that moment.

The type byte is read from the 8-bit data bus in the second acknowledge cycle only. It is scaled by four to give a 10-bit pointer into the interrupt vector table. That pointer leaves the block on a valid/ready output. Valid rises after T4 of the second cycle and stays high, with the pointer held constant, until the consumer raises ready. The transfer happens in the first cycle where both are high, and the block then goes back to idle. Back-pressure therefore holds the block in its result state. Any start request that arrives during that time is dropped.

Top module: `intack_seq`

## Requirements
- R1: After reset, ale_o is 0, ack_n_o is 1, lock_o is 0 and vec_valid_o is 0.
- R2: A start_i pulse sampled while idle begins a sequence of exactly eight bus states: T1, T2, T3, T4 of the first cycle, then the same four states of the second. The first state is presented in the cycle after the edge that samples start_i. ale_o is 1 only in the T1 states.
- R3: ack_n_o is 0 in T2 and T3 of both acknowledge cycles and is 1 in every other state.
- R4: lock_o is 1 from T2 of the first cycle through T1 of the second cycle (four clock cycles). It is 0 from T2 of the second cycle onward and at all other times.
- R5: hold_ok_o equals hold_req_i while the block is idle or presenting its result, and is 0 in every T1 to T4 state.
- R6: The type byte is taken from data_i on the clock edge that ends T3 of the second cycle. The value of data_i at any other time has no effect on the pointer.
- R7: The pointer vec_addr_o is the captured type byte multiplied by four. The byte sits in bits 9:2 and bits 1:0 are 0. vec_valid_o rises in the cycle after T4 of the second cycle.
- R8: While vec_valid_o is 1 and vec_ready_i is 0, vec_valid_o stays 1 and vec_addr_o does not change. When both are 1 at a clock edge, the pointer is transferred and the block returns to idle.
- R9: A start_i pulse that arrives during a sequence, or while a result is waiting for ready, is ignored. It does not restart or extend the sequence, and no extra sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to run the acknowledge pair |
| data_i | input | 8 | Data bus carrying the type byte |
| hold_req_i | input | 1 | Pending bus-hold request from another master |
| vec_ready_i | input | 1 | Consumer accepts the pointer |
| ale_o | output | 1 | Address latch enable, high in T1 |
| ack_n_o | output | 1 | Acknowledge strobe, active low in T2 and T3 |
| lock_o | output | 1 | Bus lock across the acknowledge pair |
| hold_ok_o | output | 1 | Hold may be granted now |
| vec_valid_o | output | 1 | Vector pointer is valid |
| vec_addr_o | output | 10 | Vector table pointer, type times four |

## Verification
The assertions assume three things about the inputs: start_i is a one-cycle pulse, the consumer keeps vec_ready_i meaningful only while a result is offered, and data_i is settled before the edge that ends T3 of the second cycle. The stimulus changes every input on the falling clock edge. It places the real type byte on data_i only in that T3 window and drives its complement at all other times. It holds hold_req_i high throughout a sequence. It adds start pulses in the middle of a sequence and during a back-pressure wait, so the rule that such pulses are dropped is exercised while all of these assumptions still hold.

// File: rtl/intack_pkg.sv
`timescale 1ns/1ps
package intack_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4,
    PH_DONE = 3'd5
  } bus_ph_e;
endpackage

// File: rtl/intack_phase_seq.sv
`timescale 1ns/1ps
module intack_phase_seq
  import intack_pkg::*;
#(
  parameter int NUM_CYC = 2,
  parameter int CYC_W   = (NUM_CYC > 1) ? $clog2(NUM_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             accept_i,
  output bus_ph_e          ph_o,
  output logic [CYC_W-1:0] cyc_o
);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(NUM_CYC - 1);

  bus_ph_e          ph_d;
  logic [CYC_W-1:0] cyc_d;

  always_comb begin
    ph_d  = ph_o;
    cyc_d = cyc_o;
    unique case (ph_o)
      PH_IDLE: if (start_i) begin
        ph_d  = PH_T1;
        cyc_d = '0;
      end
      PH_T1: ph_d = PH_T2;
      PH_T2: ph_d = PH_T3;
      PH_T3: ph_d = PH_T4;
      PH_T4: begin
        if (cyc_o == LAST_CYC) begin
          ph_d = PH_DONE;
        end else begin
          ph_d  = PH_T1;
          cyc_d = cyc_o + 1'b1;
        end
      end
      PH_DONE: if (accept_i) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_o  <= PH_IDLE;
      cyc_o <= '0;
    end else begin
      ph_o  <= ph_d;
      cyc_o <= cyc_d;
    end
  end

  // A new first cycle only follows idle; a start pulse mid-sequence cannot re-enter T1 of cycle 0
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_o != PH_IDLE) |=> !(ph_o == PH_T1 && cyc_o == '0));

  assert_result_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_o == PH_DONE && !accept_i) |=> (ph_o == PH_DONE));
endmodule

// File: rtl/intack_strobe_gen.sv
`timescale 1ns/1ps
module intack_strobe_gen
  import intack_pkg::*;
#(
  parameter int NUM_CYC = 2,
  parameter int CYC_W   = (NUM_CYC > 1) ? $clog2(NUM_CYC) : 1
) (
  input  bus_ph_e          ph_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic             hold_req_i,
  output logic             ale_o,
  output logic             ack_n_o,
  output logic             lock_o,
  output logic             hold_ok_o
);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(NUM_CYC - 1);

  logic on_bus;
  logic before_lock;
  logic after_lock;

  always_comb begin
    on_bus      = (ph_i == PH_T1) || (ph_i == PH_T2) ||
                  (ph_i == PH_T3) || (ph_i == PH_T4);
    before_lock = (cyc_i == '0) && (ph_i == PH_T1);
    after_lock  = (cyc_i == LAST_CYC) && (ph_i != PH_T1);
    ale_o       = (ph_i == PH_T1);
    ack_n_o     = !((ph_i == PH_T2) || (ph_i == PH_T3));
    lock_o      = on_bus && !before_lock && !after_lock;
    hold_ok_o   = hold_req_i && !on_bus;
  end
endmodule

// File: rtl/intack_vec_cap.sv
`timescale 1ns/1ps
module intack_vec_cap
  import intack_pkg::*;
#(
  parameter int NUM_CYC  = 2,
  parameter int CYC_W    = (NUM_CYC > 1) ? $clog2(NUM_CYC) : 1,
  parameter int DATA_W   = 8,
  parameter int SCALE_SH = 2,
  parameter int ADDR_W   = DATA_W + SCALE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ph_e           ph_i,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(NUM_CYC - 1);

  logic [DATA_W-1:0] type_q;
  logic              cap_en;

  assign cap_en = (ph_i == PH_T3) && (cyc_i == LAST_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      type_q <= '0;
    else if (cap_en) type_q <= data_i;
  end

  assign vec_addr_o  = {type_q, {SCALE_SH{1'b0}}};
  assign vec_valid_o = (ph_i == PH_DONE);

  // Once the result is offered, the captured byte no longer follows the bus
  assert_type_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_i == PH_DONE) |=> $stable(type_q));
endmodule

// File: rtl/intack_seq.sv
`timescale 1ns/1ps
module intack_seq
  import intack_pkg::*;
#(
  parameter int NUM_CYC  = 2,
  parameter int DATA_W   = 8,
  parameter int SCALE_SH = 2,
  parameter int ADDR_W   = DATA_W + SCALE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hold_req_i,
  input  logic              vec_ready_i,
  output logic              ale_o,
  output logic              ack_n_o,
  output logic              lock_o,
  output logic              hold_ok_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  localparam int CYC_W = (NUM_CYC > 1) ? $clog2(NUM_CYC) : 1;

  bus_ph_e          ph;
  logic [CYC_W-1:0] cyc;
  logic             accept;

  assign accept = vec_valid_o && vec_ready_i;

  intack_phase_seq #(.NUM_CYC(NUM_CYC), .CYC_W(CYC_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_i (accept),
    .ph_o     (ph),
    .cyc_o    (cyc)
  );

  intack_strobe_gen #(.NUM_CYC(NUM_CYC), .CYC_W(CYC_W)) strb_i (
    .ph_i       (ph),
    .cyc_i      (cyc),
    .hold_req_i (hold_req_i),
    .ale_o      (ale_o),
    .ack_n_o    (ack_n_o),
    .lock_o     (lock_o),
    .hold_ok_o  (hold_ok_o)
  );

  intack_vec_cap #(
    .NUM_CYC(NUM_CYC), .CYC_W(CYC_W), .DATA_W(DATA_W),
    .SCALE_SH(SCALE_SH), .ADDR_W(ADDR_W)
  ) cap_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ph_i        (ph),
    .cyc_i       (cyc),
    .data_i      (data_i),
    .vec_valid_o (vec_valid_o),
    .vec_addr_o  (vec_addr_o)
  );

  assert_ale_then_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ack_n_o);
  assert_strobe_two_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n_o) |=> !ack_n_o);
  assert_lock_rises_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> !ack_n_o);
  assert_lock_drops_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> !ack_n_o);
  assert_no_hold_in_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |-> !hold_ok_o);
  assert_vec_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_addr_o)));
  assert_vec_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid_o) |-> (vec_addr_o[SCALE_SH-1:0] == '0));
endmodule

// File: tb/intack_seq_tb_top.sv
`timescale 1ns/1ps
module intack_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       hold_req_i = 1'b0;
  logic       vec_ready_i = 1'b0;
  logic       ale_o, ack_n_o, lock_o, hold_ok_o, vec_valid_o;
  logic [9:0] vec_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [9:0] exp_q[$];

  always #2.5 clk = ~clk;

  intack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .hold_req_i(hold_req_i), .vec_ready_i(vec_ready_i),
    .ale_o(ale_o), .ack_n_o(ack_n_o), .lock_o(lock_o), .hold_ok_o(hold_ok_o),
    .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Monitor: pops an expected pointer on every transfer
  always begin
    @(negedge clk);
    #1;
    if (rst_n && vec_valid_o && vec_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected transfer", int'(vec_addr_o), 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(vec_addr_o == e, "R7 pointer = type*4", int'(vec_addr_o), int'(e));
      end
    end
  end

  // Driver: one acknowledge pair, optional mid-sequence start, back-pressure wait
  task automatic run_seq(input logic [7:0] ty, input int wait_cyc, input bit stray_start);
    @(negedge clk);
    start_i = 1'b1;
    hold_req_i = 1'b1;
    data_i = ~ty;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      int ph;
      ph = k % 4;
      chk(ale_o == (ph == 0), "R2 ale only in T1", ale_o, ph == 0);
      chk(ack_n_o == !(ph == 1 || ph == 2), "R3 strobe in T2/T3", ack_n_o, !(ph == 1 || ph == 2));
      chk(lock_o == (k >= 1 && k <= 4), "R4 lock window", lock_o, k >= 1 && k <= 4);
      chk(hold_ok_o == 1'b0, "R5 hold blocked on bus", hold_ok_o, 0);
      chk(vec_valid_o == 1'b0, "R7 no valid during bus", vec_valid_o, 0);
      data_i = (k == 6) ? ty : ~ty;  // R6: only the T3 edge of cycle 2 sees the real byte
      start_i = stray_start && (k == 2);  // R9
      @(negedge clk);
    end
    start_i = 1'b0;
    data_i = 8'h5A ^ ty;
    exp_q.push_back({ty, 2'b00});
    chk(vec_valid_o == 1'b1, "R7 valid after T4", vec_valid_o, 1);
    chk(hold_ok_o == 1'b1, "R5 hold ok while presenting", hold_ok_o, 1);
    for (int w = 0; w < wait_cyc; w++) begin
      start_i = (w == 0);  // R9: start while result waits
      @(negedge clk);
      start_i = 1'b0;
      chk(vec_valid_o == 1'b1, "R8 valid held", vec_valid_o, 1);
      chk(vec_addr_o == {ty, 2'b00}, "R8 pointer stable / R6 late data ignored",
          int'(vec_addr_o), int'({ty, 2'b00}));
    end
    vec_ready_i = 1'b1;
    @(negedge clk);
    vec_ready_i = 1'b0;
    chk(vec_valid_o == 1'b0, "R8 idle after transfer", vec_valid_o, 0);
    for (int q = 0; q < 3; q++) begin
      chk(ale_o == 1'b0, "R9 no extra sequence", ale_o, 0);
      @(negedge clk);
    end
    hold_req_i = 1'b0;
    #0;
    chk(hold_ok_o == 1'b0, "R5 follows request when idle", hold_ok_o, 0);
  endtask

  initial begin
    #1;
    chk(ale_o == 1'b0, "R1 ale reset", ale_o, 0);
    chk(ack_n_o == 1'b1, "R1 strobe reset", ack_n_o, 1);
    chk(lock_o == 1'b0, "R1 lock reset", lock_o, 0);
    chk(vec_valid_o == 1'b0, "R1 valid reset", vec_valid_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    hold_req_i = 1'b1;
    #0;
    chk(hold_ok_o == 1'b1, "R5 idle passes request", hold_ok_o, 1);
    run_seq(8'h08, 0, 1'b0);
    run_seq(8'hFF, 3, 1'b1);
    run_seq(8'h00, 1, 1'b0);
    run_seq(8'hA5, 5, 1'b1);
    run_seq(8'h3C, 0, 1'b1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
    summary();
  end

  initial begin
    #50000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    summary();
  end
endmodule